// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block sits behind a management register port and opens a large internal register space (up to 32 devices of 32 registers each) through only two host-visible registers. The host places a command word in the command register. The word selects an internal device and register and says whether to read or write. The bridge then runs the access on an internal register bus. While the access is in flight it shows a busy flag in the top bit of the command register. A write takes its value from the data register, which the host fills beforehand. A read leaves its result in the data register. The serial framing of the management bus is outside this block. The host side is a plain parallel port that carries a bus address, a register number and single-cycle read and write strobes.

The bridge answers only to the bus address given on its strap input. When the strap is zero, no indirection takes place. Each host access goes straight to the internal bus, with the host's bus address used as the device and the host's register number used as the register. Every internal access takes a configurable number of cycles, from 1 to 15. This makes the busy window long enough to observe.

Top module: `mgmt_ind_bridge`

## Requirements
- R1: After reset the command register reads 0x0000 (not busy, no error, fields zero), the data register reads 0x0000, and no internal strobe has been issued.
- R2: In strapped mode, writing a command whose bits 15:10 are 100101 (0x9400 base) issues exactly one internal write strobe, one cycle after the host write. The strobe carries the command's device and register fields, and its data is the value the data register held when the command was accepted.
- R3: Bit 15 of the command register reads 1 for exactly cfg_lat_i cycles after a command is accepted, and a latency of 0 is treated as 1.
- R4: A command whose bits 15:10 are 100110 (0x9800 base) performs an internal read. Once busy has cleared, the data register holds the value the internal bus returned.
- R5: The command word carries the device in bits 9:5 and the register in bits 4:0. Reading the command register returns the last accepted fields in those same bits, with the collision error in bit 14 and zeros in bits 13:10.
- R6: With the strap at zero, a host write issues one internal write strobe in the following cycle. The strobe uses device = host bus address, register = host register number and data = host write data.
- R7: With the strap at zero, a host read returns hst_rvalid_o with the internal read value exactly cfg_lat_i cycles after the cycle in which the request was sampled.
- R8: A command-register write that arrives while busy is ignored, and it sets the sticky error bit 14. The next accepted command clears that bit.
- R9: A command word whose bits 15:10 match neither encoding is ignored: busy stays clear, no strobe is issued and the fields read back unchanged.
- R10: In strapped mode, host accesses to any bus address other than the strap are ignored and produce no hst_rvalid_o. A data-register write made while busy is ignored.
- R11: In strapped mode, a host read of the strap address returns hst_rvalid_o in the next cycle. Register numbers other than 0 and 1 read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | ID_W | Bridge bus address; zero selects direct mode |
| cfg_lat_i | input | LAT_W | Internal access latency in cycles (0 acts as 1) |
| hst_wr_i | input | 1 | Host write strobe |
| hst_rd_i | input | 1 | Host read strobe |
| hst_phy_i | input | ID_W | Host bus address |
| hst_reg_i | input | ID_W | Host register number |
| hst_wdata_i | input | DATA_W | Host write data |
| hst_rdata_o | output | DATA_W | Host read data |
| hst_rvalid_o | output | 1 | Host read data valid |
| ibus_stb_o | output | 1 | Internal access start strobe (one cycle) |
| ibus_we_o | output | 1 | Internal access is a write |
| ibus_dev_o | output | ID_W | Internal device address |
| ibus_reg_o | output | ID_W | Internal register number |
| ibus_wdata_o | output | DATA_W | Internal write data |
| ibus_rdata_i | input | DATA_W | Internal read data, sampled on the last access cycle |

## Verification
A strapped register read answers in the cycle after the request. The internal strobe appears in the cycle after the accepting edge. The busy bit is seen by exactly cfg_lat_i back-to-back command-register reads that start right after the command. A direct-mode read result arrives cfg_lat_i cycles after the request. Every input is driven and every output sampled on the falling edge. The bench counts falling edges from the accepting edge and compares that count with the expected latency, so a window that is one cycle too long or too short is caught. Results that must stay unchanged, such as the fields after an invalid opcode, the data register after a late write and the strobe count, are read back through the host port or counted on the internal bus before the next stimulus.

// File: rtl/mib_pkg.sv
package mib_pkg;
  localparam int unsigned OPC_BITS = 6;
  localparam logic [OPC_BITS-1:0] OPC_RD = 6'b100110;
  localparam logic [OPC_BITS-1:0] OPC_WR = 6'b100101;
  localparam int unsigned CMD_IDX  = 0;
  localparam int unsigned DATA_IDX = 1;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/mib_cmd_decode.sv
module mib_cmd_decode
  import mib_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ID_W   = 5
) (
  input  logic [DATA_W-1:0] word_i,
  output op_e               op_o,
  output logic [ID_W-1:0]   dev_o,
  output logic [ID_W-1:0]   reg_o
);
  localparam int unsigned OPC_W = DATA_W - 2*ID_W;

  logic [OPC_W-1:0] opc;

  assign opc   = word_i[DATA_W-1 -: OPC_W];
  assign dev_o = word_i[2*ID_W-1 -: ID_W];
  assign reg_o = word_i[ID_W-1:0];

  always_comb begin
    op_o = OP_NONE;
    if (opc == OPC_RD)      op_o = OP_RD;
    else if (opc == OPC_WR) op_o = OP_WR;
  end
endmodule

// File: rtl/mib_access_engine.sv
module mib_access_engine #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned LAT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ID_W-1:0]   dev_i,
  input  logic [ID_W-1:0]   reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic              busy_o,
  output logic              last_o,
  output logic              stb_o,
  output logic              we_o,
  output logic [ID_W-1:0]   dev_o,
  output logic [ID_W-1:0]   reg_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  logic             busy_q, stb_q, we_q;
  logic [LAT_W-1:0] cnt_q;
  logic [ID_W-1:0]  dev_q, reg_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      stb_q   <= 1'b0;
      we_q    <= 1'b0;
      cnt_q   <= '0;
      dev_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        stb_q   <= 1'b1;
        cnt_q   <= (lat_i == '0) ? LAT_ONE : lat_i;
        we_q    <= we_i;
        dev_q   <= dev_i;
        reg_q   <= reg_i;
        wdata_q <= wdata_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q - LAT_ONE;
        if (cnt_q == LAT_ONE) busy_q <= 1'b0;
      end
    end
  end

  // final cycle of the access: read data is sampled here
  assign last_o  = busy_q && (cnt_q == LAT_ONE);
  assign busy_o  = busy_q;
  assign stb_o   = stb_q;
  assign we_o    = we_q;
  assign dev_o   = dev_q;
  assign reg_o   = reg_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/mgmt_ind_bridge.sv
module mgmt_ind_bridge
  import mib_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned LAT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   strap_i,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  input  logic              hst_wr_i,
  input  logic              hst_rd_i,
  input  logic [ID_W-1:0]   hst_phy_i,
  input  logic [ID_W-1:0]   hst_reg_i,
  input  logic [DATA_W-1:0] hst_wdata_i,
  output logic [DATA_W-1:0] hst_rdata_o,
  output logic              hst_rvalid_o,
  output logic              ibus_stb_o,
  output logic              ibus_we_o,
  output logic [ID_W-1:0]   ibus_dev_o,
  output logic [ID_W-1:0]   ibus_reg_o,
  output logic [DATA_W-1:0] ibus_wdata_o,
  input  logic [DATA_W-1:0] ibus_rdata_i
);
  localparam int unsigned PAD_W = DATA_W - 2 - 2*ID_W;

  op_e              dec_op;
  logic [ID_W-1:0]  dec_dev, dec_reg;
  logic             direct, hit, sel_cmd, sel_dat, cmd_wr;
  logic             ind_start, dir_start, eng_start, eng_we;
  logic [ID_W-1:0]  eng_dev, eng_reg;
  logic [DATA_W-1:0] eng_wdata, cmd_view, reg_view;
  logic             eng_busy, eng_last;

  logic [DATA_W-1:0] data_q, rdata_q;
  logic [ID_W-1:0]   fld_dev_q, fld_reg_q;
  logic              err_q, rvalid_q, src_dir_q;

  mib_cmd_decode #(.DATA_W(DATA_W), .ID_W(ID_W)) u_dec (
    .word_i (hst_wdata_i),
    .op_o   (dec_op),
    .dev_o  (dec_dev),
    .reg_o  (dec_reg)
  );

  assign direct    = (strap_i == '0);
  assign hit       = !direct && (hst_phy_i == strap_i);
  assign sel_cmd   = hit && (hst_reg_i == ID_W'(CMD_IDX));
  assign sel_dat   = hit && (hst_reg_i == ID_W'(DATA_IDX));
  assign cmd_wr    = hst_wr_i && sel_cmd;
  assign ind_start = cmd_wr && !eng_busy && (dec_op != OP_NONE);
  assign dir_start = direct && (hst_wr_i || hst_rd_i) && !eng_busy;
  assign eng_start = ind_start || dir_start;

  assign eng_we    = direct ? hst_wr_i    : (dec_op == OP_WR);
  assign eng_dev   = direct ? hst_phy_i   : dec_dev;
  assign eng_reg   = direct ? hst_reg_i   : dec_reg;
  assign eng_wdata = direct ? hst_wdata_i : data_q;

  mib_access_engine #(.DATA_W(DATA_W), .ID_W(ID_W), .LAT_W(LAT_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .we_i    (eng_we),
    .dev_i   (eng_dev),
    .reg_i   (eng_reg),
    .wdata_i (eng_wdata),
    .lat_i   (cfg_lat_i),
    .busy_o  (eng_busy),
    .last_o  (eng_last),
    .stb_o   (ibus_stb_o),
    .we_o    (ibus_we_o),
    .dev_o   (ibus_dev_o),
    .reg_o   (ibus_reg_o),
    .wdata_o (ibus_wdata_o)
  );

  assign cmd_view = {eng_busy, err_q, {PAD_W{1'b0}}, fld_dev_q, fld_reg_q};

  always_comb begin
    reg_view = '0;
    if (sel_cmd)      reg_view = cmd_view;
    else if (sel_dat) reg_view = data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      err_q     <= 1'b0;
      fld_dev_q <= '0;
      fld_reg_q <= '0;
      src_dir_q <= 1'b0;
    end else begin
      if (eng_last && !ibus_we_o && !src_dir_q)
        data_q <= ibus_rdata_i;
      else if (hst_wr_i && sel_dat && !eng_busy)
        data_q <= hst_wdata_i;

      if (cmd_wr && eng_busy) err_q <= 1'b1;
      else if (ind_start)     err_q <= 1'b0;

      if (ind_start) begin
        fld_dev_q <= dec_dev;
        fld_reg_q <= dec_reg;
      end
      if (eng_start) src_dir_q <= direct;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      if (eng_last && !ibus_we_o && src_dir_q) begin
        rvalid_q <= 1'b1;
        rdata_q  <= ibus_rdata_i;
      end else if (hst_rd_i && !hst_wr_i && hit) begin
        rvalid_q <= 1'b1;
        rdata_q  <= reg_view;
      end
    end
  end

  assign hst_rdata_o  = rdata_q;
  assign hst_rvalid_o = rvalid_q;
endmodule

// File: rtl/mib_chk.sv
module mib_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned LAT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_i,
  input logic              busy_i,
  input logic              err_i,
  input logic              we_i,
  input logic [ID_W-1:0]   dev_i,
  input logic [ID_W-1:0]   reg_i,
  input logic [DATA_W-1:0] wdata_i
);
  localparam int unsigned MAX_RUN = (1 << LAT_W) - 1;

  logic [LAT_W:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R2
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !stb_i);

  // R3
  stb_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> stb_i);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= (LAT_W+1)'(MAX_RUN));

  // R2
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !stb_i) |-> ($stable(dev_i) && $stable(reg_i) && $stable(we_i) && $stable(wdata_i)));

  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $past(busy_i));
endmodule

bind mgmt_ind_bridge mib_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .LAT_W(LAT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .stb_i   (ibus_stb_o),
  .busy_i  (eng_busy),
  .err_i   (err_q),
  .we_i    (ibus_we_o),
  .dev_i   (ibus_dev_o),
  .reg_i   (ibus_reg_o),
  .wdata_i (ibus_wdata_o)
);

// File: tb/sim_mgmt_ind_bridge.sv
module sim_mgmt_ind_bridge;
  localparam int DATA_W = 16;
  localparam int ID_W   = 5;
  localparam int LAT_W  = 4;
  localparam logic [4:0] STRAP = 5'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ID_W-1:0] strap = STRAP;
  logic [LAT_W-1:0] lat = 4'd1;
  logic wr = 1'b0, rd = 1'b0;
  logic [ID_W-1:0] phy = '0, rg = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata, ib_wdata, ib_rdata;
  logic rvalid, ib_stb, ib_we;
  logic [ID_W-1:0] ib_dev, ib_reg;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [15:0] mem [32][32];

  always #2 clk = ~clk;

  mgmt_ind_bridge #(.DATA_W(DATA_W), .ID_W(ID_W), .LAT_W(LAT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .cfg_lat_i(lat),
    .hst_wr_i(wr), .hst_rd_i(rd), .hst_phy_i(phy), .hst_reg_i(rg),
    .hst_wdata_i(wdata), .hst_rdata_o(rdata), .hst_rvalid_o(rvalid),
    .ibus_stb_o(ib_stb), .ibus_we_o(ib_we), .ibus_dev_o(ib_dev),
    .ibus_reg_o(ib_reg), .ibus_wdata_o(ib_wdata), .ibus_rdata_i(ib_rdata)
  );

  // internal register space model
  assign ib_rdata = mem[ib_dev][ib_reg];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 32; d++)
        for (int r = 0; r < 32; r++)
          mem[d][r] <= 16'hA000 | 16'(d << 5) | 16'(r);
      stb_cnt <= 0;
    end else if (ib_stb) begin
      stb_cnt <= stb_cnt + 1;
      if (ib_we) mem[ib_dev][ib_reg] <= ib_wdata;
    end
  end

  function automatic logic [15:0] pat(input int d, input int r);
    return 16'hA000 | 16'(d << 5) | 16'(r);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic hwrite(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    wr = 1'b1; phy = p; rg = r; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic hread(input logic [4:0] p, input logic [4:0] r, output logic [15:0] d, output logic v);
    rd = 1'b1; phy = p; rg = r;
    @(negedge clk);
    d = rdata; v = rvalid;
    rd = 1'b0;
  endtask

  task automatic poll_busy(output int n);
    logic [15:0] d; logic v;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      hread(STRAP, 5'd0, d, v);
      if (d[15]) n++;
      else break;
    end
  endtask

  task automatic dread(input logic [4:0] p, input logic [4:0] r, output logic [15:0] d, output int k);
    rd = 1'b1; phy = p; rg = r;
    @(negedge clk);
    rd = 1'b0;
    k = 0;
    while (!rvalid && k < 40) begin
      @(negedge clk);
      k++;
    end
    d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic v;
    hread(STRAP, 5'd0, d, v);
    check(v && d == 16'h0000, "R1 cmd reg", d, 16'h0000);
    hread(STRAP, 5'd1, d, v);
    check(v && d == 16'h0000, "R1 data reg", d, 16'h0000);
    check(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);
  endtask

  task automatic t_ind_write;
    logic [15:0] d; logic v; int n, s0;
    lat = 4'd3;
    s0 = stb_cnt;
    hwrite(STRAP, 5'd1, 16'hBEEF);
    hwrite(STRAP, 5'd0, 16'h9400 | (16'd7 << 5) | 16'd3);
    check(ib_stb && ib_we && ib_dev == 5'd7 && ib_reg == 5'd3 && ib_wdata == 16'hBEEF,
          "R2 strobe fields", {ib_stb, ib_we, ib_dev, ib_reg, ib_wdata}, {2'b11, 5'd7, 5'd3, 16'hBEEF});
    poll_busy(n);
    check(n == 3, "R3 busy window lat3", n, 3);
    check(mem[7][3] == 16'hBEEF, "R2 target written", mem[7][3], 16'hBEEF);
    check(stb_cnt == s0 + 1, "R2 single strobe", stb_cnt - s0, 1);
    hread(STRAP, 5'd0, d, v);
    check(d == 16'h00E3, "R5 field readback", d, 16'h00E3);
  endtask

  task automatic t_ind_read(input logic [3:0] l, input int exp_n);
    logic [15:0] d; logic v; int n;
    lat = l;
    hwrite(STRAP, 5'd0, 16'h9800 | (16'd12 << 5) | 16'd30);
    poll_busy(n);
    check(n == exp_n, "R3 busy window", n, exp_n);
    hread(STRAP, 5'd1, d, v);
    check(v && d == pat(12, 30), "R4 read result", d, pat(12, 30));
  endtask

  task automatic t_collision;
    logic [15:0] d; logic v; int n, s0;
    lat = 4'd10;
    s0 = stb_cnt;
    hwrite(STRAP, 5'd0, 16'h9800 | (16'd5 << 5) | 16'd6);
    hwrite(STRAP, 5'd0, 16'h9800 | (16'd9 << 5) | 16'd9);
    poll_busy(n);
    hread(STRAP, 5'd0, d, v);
    check(d == (16'h4000 | (16'd5 << 5) | 16'd6), "R8 ignored and error set", d, 16'h4000 | (16'd5 << 5) | 16'd6);
    check(stb_cnt == s0 + 1, "R8 no second strobe", stb_cnt - s0, 1);
    hread(STRAP, 5'd1, d, v);
    check(d == pat(5, 6), "R8 first command result", d, pat(5, 6));
    lat = 4'd1;
    hwrite(STRAP, 5'd0, 16'h9800 | (16'd1 << 5) | 16'd1);
    poll_busy(n);
    hread(STRAP, 5'd0, d, v);
    check(d == 16'h0021, "R8 error cleared", d, 16'h0021);
  endtask

  task automatic t_invalid;
    logic [15:0] d; logic v; int s0;
    s0 = stb_cnt;
    hwrite(STRAP, 5'd0, 16'h1800 | (16'd3 << 5) | 16'd1);
    hread(STRAP, 5'd0, d, v);
    check(d == 16'h0021, "R9 bad opcode ignored", d, 16'h0021);
    hwrite(STRAP, 5'd0, 16'h9C00 | (16'd4 << 5) | 16'd2);
    hread(STRAP, 5'd0, d, v);
    check(d == 16'h0021, "R9 bad opcode 9C ignored", d, 16'h0021);
    check(stb_cnt == s0, "R9 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_data_guard;
    logic [15:0] d; logic v; int n;
    lat = 4'd6;
    hwrite(STRAP, 5'd1, 16'h1111);
    hwrite(STRAP, 5'd0, 16'h9400 | (16'd2 << 5) | 16'd4);
    hwrite(STRAP, 5'd1, 16'h2222);
    poll_busy(n);
    hread(STRAP, 5'd1, d, v);
    check(d == 16'h1111, "R10 data write while busy ignored", d, 16'h1111);
    check(mem[2][4] == 16'h1111, "R10 staged data used", mem[2][4], 16'h1111);
    hwrite(STRAP ^ 5'h01, 5'd1, 16'h7777);
    hread(STRAP, 5'd1, d, v);
    check(d == 16'h1111, "R10 foreign address write ignored", d, 16'h1111);
    hread(STRAP ^ 5'h01, 5'd1, d, v);
    check(!v, "R10 foreign address no response", v, 0);
  endtask

  task automatic t_unmapped;
    logic [15:0] d; logic v;
    hread(STRAP, 5'd5, d, v);
    check(v, "R11 rvalid next cycle", v, 1);
    check(d == 16'h0000, "R11 unmapped reads zero", d, 16'h0000);
  endtask

  task automatic t_direct;
    logic [15:0] d; int k, n;
    strap = 5'd0;
    lat = 4'd4;
    hwrite(5'd9, 5'd2, 16'h55AA);
    check(ib_stb && ib_we && ib_dev == 5'd9 && ib_reg == 5'd2 && ib_wdata == 16'h55AA,
          "R6 direct write strobe", {ib_stb, ib_we, ib_dev, ib_reg, ib_wdata}, {2'b11, 5'd9, 5'd2, 16'h55AA});
    repeat (5) @(negedge clk);
    dread(5'd9, 5'd2, d, k);
    check(d == 16'h55AA, "R6 direct write landed", d, 16'h55AA);
    check(k == 4, "R7 direct read latency 4", k, 4);
    @(negedge clk);
    lat = 4'd1;
    dread(5'd20, 5'd17, d, k);
    check(d == pat(20, 17) && k == 1, "R7 direct read latency 1", {d, 16'(k)}, {pat(20, 17), 16'd1});
    n = 0;
    strap = STRAP;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ind_write();
    t_ind_read(4'd1, 1);
    t_ind_read(4'd0, 1);
    t_ind_read(4'd15, 15);
    t_collision();
    t_invalid();
    t_data_guard();
    t_unmapped();
    t_direct();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule